// File: doc/BRIEF.md
# ESF Bit-Oriented Message Engine

This block carries short bit-oriented messages over the 4 kbit/s facility data link that rides in the S-bit positions of an ESF superframe. A one-cycle data-link strobe marks each data-link bit slot. At each strobe the block drives one outgoing bit and samples one incoming bit. Superframe alignment is handled elsewhere. The strobe arrives only in the slots that belong to the data link.

On the transmit side, a 6-bit code is wrapped in a 16-bit pattern: eight ones, a zero, the six code bits (least significant first) and a closing zero. The pattern repeats for as long as the send-enable bit is set. While the enable is clear, the output passes an external idle or HDLC bit stream. The mode only changes at a 16-bit pattern boundary, so a pattern is never cut short.

On the receive side, the block hunts the incoming stream for valid patterns and accepts a code once it has been seen twice in a row. The accepted code is stored. It is also compared with a programmable match code. Live status bits show "message present" and "message matched". Sticky write-one-to-clear event bits record new receptions and new matches. An interrupt output is raised for every event bit that is not masked.

Top module: `bom_engine`

## Requirements
- R1: After reset, every register reads 0, `tx_bit` is 0 and `irq` is 0.
- R2: With send-enable (bit 0 of address 0) set, each run of 16 strobes starting at a pattern boundary sends 1,1,1,1,1,1,1,1,0, then the code bits from address 1 starting with bit 0, then 0. The first strobe after reset is a pattern boundary. `tx_bit` takes each bit one clock after its strobe.
- R3: With send-enable clear, `tx_bit` takes the value of `tx_idle_bit` sampled at each strobe. Changes to send-enable take effect only at the next pattern boundary, in both directions.
- R4: A received code is accepted only when the same valid pattern ends on two strobes exactly 16 strobes apart. Acceptance writes the code to address 3, sets live bit 0 (address 4) and sets event bit 0 (address 5). A single valid pattern changes none of these.
- R5: While reception is live, repeated patterns with an unchanged code do not set event bit 0 again. A different code that is confirmed twice does set it, and updates address 3.
- R6: If the strobe where the next valid pattern is due does not complete one, live bit 0 clears. The next accepted code then sets event bit 0 again, even if the code is unchanged.
- R7: Live bit 1 (address 4) is set while reception is live and the stored code equals the match code (address 2). Event bit 1 is set on each rising edge of live bit 1, including one caused by writing the match register.
- R8: Writing a 1 to a bit of address 5 clears that event bit. Writing a 0 leaves it unchanged. A new event in the same cycle as the write wins over the clear.
- R9: `irq` is the OR over the event bits that have a 0 in the matching bit of the mask register (address 6).
- R10: Addresses 0, 1, 2 and 6 read back what was written, limited to their widths (1, 6, 6 and 2 bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dl_strobe | input | 1 | One-cycle pulse per data-link bit slot |
| rx_bit | input | 1 | Received data-link bit, sampled on the strobe |
| tx_idle_bit | input | 1 | Idle/HDLC bit passed through when send-enable is clear |
| tx_bit | output | 1 | Transmitted data-link bit |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The bench switches send-enable on and off in the middle of a pattern. A design that switched at once would emit a truncated pattern or cut idle data short, and the bit-by-bit comparison would show it. It sends a single valid pattern to catch a receiver that accepts on the first sighting, and re-sends an unchanged code to catch a receiver that raises the event for every repeat. It breaks the stream and then sends the same code again, so that a design which never drops the live state, or never re-arms its event, is exposed. It programs the match code while a message is already live, which finds a match detector that only looks at new receptions. It toggles the mask bits to find an interrupt that ignores the mask or takes it from the wrong bit.

// File: rtl/bom_pkg.sv
package bom_pkg;
    localparam int REG_AW = 3;
    localparam int REG_DW = 8;

    typedef enum logic [REG_AW-1:0] {
        RA_CTRL   = 3'd0,
        RA_TXCODE = 3'd1,
        RA_MATCH  = 3'd2,
        RA_RXCODE = 3'd3,
        RA_LIVE   = 3'd4,
        RA_ISTAT  = 3'd5,
        RA_MASK   = 3'd6
    } reg_addr_e;

    localparam int EV_RX    = 0;
    localparam int EV_MATCH = 1;
    localparam int EV_N     = 2;
endpackage

// File: rtl/bom_tx.sv
module bom_tx #(
    parameter int FLAG_W = 8,
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              send_en,
    input  logic [CODE_W-1:0] send_code,
    input  logic              idle_bit,
    output logic              tx_bit
);
    localparam int PAT_LEN = FLAG_W + CODE_W + 2;
    localparam int PW      = $clog2(PAT_LEN);

    typedef struct packed {
        logic [PW-1:0]     pos;
        logic              mode;
        logic [CODE_W-1:0] code;
        logic              txb;
    } tx_st_t;

    tx_st_t st_d, st_q;
    logic              at_boundary;
    logic              mode_now;
    logic [CODE_W-1:0] code_now;
    logic [PAT_LEN-1:0] pat_vec;

    assign at_boundary = (st_q.pos == '0);
    assign mode_now    = at_boundary ? send_en   : st_q.mode;
    assign code_now    = at_boundary ? send_code : st_q.code;

    for (genvar g = 0; g < PAT_LEN; g++) begin : g_pat
        if (g < FLAG_W) begin : g_flag
            assign pat_vec[g] = 1'b1;
        end else if (g == FLAG_W || g == PAT_LEN - 1) begin : g_sep
            assign pat_vec[g] = 1'b0;
        end else begin : g_code
            assign pat_vec[g] = code_now[g-FLAG_W-1];
        end
    end

    always_comb begin
        st_d = st_q;
        if (strobe) begin
            st_d.mode = mode_now;
            st_d.code = code_now;
            st_d.txb  = mode_now ? pat_vec[st_q.pos] : idle_bit;
            st_d.pos  = (st_q.pos == PW'(PAT_LEN - 1)) ? '0 : st_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_bit = st_q.txb;

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(tx_bit)); // R2
    AST_TX_FLAG_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && st_q.mode && st_q.pos != '0 && st_q.pos < PW'(FLAG_W)) |=> tx_bit); // R2
    AST_TX_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !st_q.mode && st_q.pos != '0) |=> (tx_bit == $past(idle_bit))); // R3
endmodule

// File: rtl/bom_rx.sv
module bom_rx #(
    parameter int FLAG_W = 8,
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              rx_bit,
    output logic [CODE_W-1:0] rx_code,
    output logic              rx_live,
    output logic              rx_event
);
    localparam int PAT_LEN = FLAG_W + CODE_W + 2;
    localparam int SW      = $clog2(PAT_LEN + 1);

    typedef struct packed {
        logic [PAT_LEN-1:0] sr;
        logic [SW-1:0]      since;
        logic [CODE_W-1:0]  cand;
        logic [CODE_W-1:0]  code;
        logic               live;
        logic               event_p;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic [PAT_LEN-1:0] sr_n;
    logic [CODE_W-1:0]  win_code;
    logic               win_valid;
    logic               confirm;

    assign sr_n = {st_q.sr[PAT_LEN-2:0], rx_bit};

    for (genvar i = 0; i < CODE_W; i++) begin : g_field
        assign win_code[i] = sr_n[PAT_LEN-2-FLAG_W-i];
    end

    assign win_valid = (sr_n[PAT_LEN-1 -: FLAG_W] == {FLAG_W{1'b1}})
                     && !sr_n[PAT_LEN-1-FLAG_W] && !sr_n[0];
    assign confirm   = win_valid && (st_q.since == SW'(PAT_LEN - 1))
                     && (win_code == st_q.cand);

    always_comb begin
        st_d = st_q;
        st_d.event_p = 1'b0;
        if (strobe) begin
            st_d.sr = sr_n;
            if (win_valid) begin
                st_d.cand  = win_code;
                st_d.since = '0;
                if (confirm) begin
                    st_d.live = 1'b1;
                    if (!st_q.live || win_code != st_q.code) begin
                        st_d.code    = win_code;
                        st_d.event_p = 1'b1;
                    end
                end
            end else if (st_q.since < SW'(PAT_LEN)) begin
                st_d.since = st_q.since + 1'b1;
                if (st_q.since == SW'(PAT_LEN - 1)) st_d.live = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.since <= SW'(PAT_LEN);
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_code  = st_q.code;
    assign rx_live  = st_q.live;
    assign rx_event = st_q.event_p;

    AST_RX_EVENT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_event |-> rx_live); // R4
    AST_RX_EVENT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_event |=> !rx_event); // R5
    AST_RX_CODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_event |-> $stable(rx_code) || !$past(rst_n)); // R4
    AST_RX_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(rx_live)); // R6
endmodule

// File: rtl/bom_irq.sv
module bom_irq #(
    parameter int CODE_W = 6,
    parameter int EV_N   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_event,
    input  logic              rx_live,
    input  logic [CODE_W-1:0] rx_code,
    input  logic [CODE_W-1:0] match_code,
    input  logic [EV_N-1:0]   clr,
    input  logic [EV_N-1:0]   mask,
    output logic [EV_N-1:0]   ev_stat,
    output logic              match_live,
    output logic              irq
);
    import bom_pkg::*;

    typedef struct packed {
        logic [EV_N-1:0] ev;
        logic            mlive;
    } irq_st_t;

    irq_st_t st_d, st_q;
    logic [EV_N-1:0] set_v;

    always_comb begin
        st_d       = st_q;
        st_d.mlive = rx_live && (rx_code == match_code);
        set_v          = '0;
        set_v[EV_RX]   = rx_event;
        set_v[EV_MATCH] = st_d.mlive && !st_q.mlive;
        st_d.ev    = (st_q.ev & ~clr) | set_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ev_stat    = st_q.ev;
    assign match_live = st_q.mlive;
    assign irq        = |(st_q.ev & ~mask);

    AST_W1C_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[EV_RX] && !rx_event) |=> !ev_stat[EV_RX]); // R8
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_event |=> ev_stat[EV_RX]); // R8
    AST_MATCH_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_live) |=> ev_stat[EV_MATCH]); // R7
    AST_MATCH_NEEDS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        match_live |-> $past(rx_live)); // R7
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_stat == '0) |-> !irq); // R9
endmodule

// File: rtl/bom_engine.sv
module bom_engine #(
    parameter int FLAG_W = 8,
    parameter int CODE_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dl_strobe,
    input  logic       rx_bit,
    input  logic       tx_idle_bit,
    output logic       tx_bit,
    input  logic       reg_we,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq
);
    import bom_pkg::*;

    typedef struct packed {
        logic              send_en;
        logic [CODE_W-1:0] send_code;
        logic [CODE_W-1:0] match_code;
        logic [EV_N-1:0]   mask;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [EV_N-1:0]   clr_v;
    logic [CODE_W-1:0] rx_code;
    logic              rx_live;
    logic              rx_event;
    logic [EV_N-1:0]   ev_stat;
    logic              match_live;

    always_comb begin
        cfg_d = cfg_q;
        clr_v = '0;
        if (reg_we) begin
            unique case (reg_addr)
                RA_CTRL:   cfg_d.send_en    = reg_wdata[0];
                RA_TXCODE: cfg_d.send_code  = reg_wdata[CODE_W-1:0];
                RA_MATCH:  cfg_d.match_code = reg_wdata[CODE_W-1:0];
                RA_ISTAT:  clr_v            = reg_wdata[EV_N-1:0];
                RA_MASK:   cfg_d.mask       = reg_wdata[EV_N-1:0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_CTRL:   reg_rdata = REG_DW'(cfg_q.send_en);
            RA_TXCODE: reg_rdata = REG_DW'(cfg_q.send_code);
            RA_MATCH:  reg_rdata = REG_DW'(cfg_q.match_code);
            RA_RXCODE: reg_rdata = REG_DW'(rx_code);
            RA_LIVE:   reg_rdata = REG_DW'({match_live, rx_live});
            RA_ISTAT:  reg_rdata = REG_DW'(ev_stat);
            RA_MASK:   reg_rdata = REG_DW'(cfg_q.mask);
            default:   reg_rdata = '0;
        endcase
    end

    bom_tx #(.FLAG_W(FLAG_W), .CODE_W(CODE_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (dl_strobe),
        .send_en   (cfg_q.send_en),
        .send_code (cfg_q.send_code),
        .idle_bit  (tx_idle_bit),
        .tx_bit    (tx_bit)
    );

    bom_rx #(.FLAG_W(FLAG_W), .CODE_W(CODE_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (dl_strobe),
        .rx_bit   (rx_bit),
        .rx_code  (rx_code),
        .rx_live  (rx_live),
        .rx_event (rx_event)
    );

    bom_irq #(.CODE_W(CODE_W), .EV_N(EV_N)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_event   (rx_event),
        .rx_live    (rx_live),
        .rx_code    (rx_code),
        .match_code (cfg_q.match_code),
        .clr        (clr_v),
        .mask       (cfg_q.mask),
        .ev_stat    (ev_stat),
        .match_live (match_live),
        .irq        (irq)
    );

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> $stable(cfg_q)); // R10
endmodule

// File: tb/bom_engine_bench.sv
module bom_engine_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dl_strobe = 1'b0;
    logic       rx_bit = 1'b0;
    logic       tx_idle_bit = 1'b0;
    logic       tx_bit;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;

    int total = 0;
    int bad   = 0;
    int sc    = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    bom_engine u_bom_engine (
        .clk(clk), .rst_n(rst_n), .dl_strobe(dl_strobe), .rx_bit(rx_bit),
        .tx_idle_bit(tx_idle_bit), .tx_bit(tx_bit), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk); reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 8'(d);
        @(negedge clk); reg_we = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk); reg_addr = 3'(a);
        #1 d = int'(reg_rdata);
    endtask

    task automatic step(input logic rxb, input logic idb, output logic txb);
        @(negedge clk); rx_bit = rxb; tx_idle_bit = idb; dl_strobe = 1'b1;
        @(negedge clk); dl_strobe = 1'b0; txb = tx_bit;
        @(negedge clk); @(negedge clk);
        sc++;
    endtask

    function automatic logic pat_bit(input int p, input logic [5:0] c);
        if (p < 8) return 1'b1;
        if (p == 8 || p == 15) return 1'b0;
        return c[p-9];
    endfunction

    task automatic send_code(input logic [5:0] c);
        logic t;
        for (int i = 0; i < 16; i++) step(pat_bit(i, c), 1'b0, t);
    endtask

    task automatic send_gap();
        logic t;
        for (int i = 0; i < 16; i++) step(1'b0, 1'b0, t);
    endtask

    task automatic t_reset();
        int d;
        for (int a = 0; a < 7; a++) begin
            rd(a, d);
            chk("R1 reg after reset", d, 0);
        end
        chk("R1 tx_bit after reset", int'(tx_bit), 0);
        chk("R1 irq after reset", int'(irq), 0);
    endtask

    task automatic t_regs();
        int d;
        wr(1, 8'hFF); rd(1, d); chk("R10 send code width", d, 8'h3F);
        wr(2, 8'hE5); rd(2, d); chk("R10 match code width", d, 8'h25);
        wr(6, 8'hFE); rd(6, d); chk("R10 mask width", d, 2);
        wr(0, 8'hFE); rd(0, d); chk("R10 ctrl width", d, 0);
        wr(1, 0); wr(2, 0); wr(6, 0);
    endtask

    task automatic t_tx_idle();
        logic t;
        int errs = 0;
        for (int i = 0; i < 20; i++) begin
            logic ib;
            ib = (i % 3 == 0);
            step(1'b0, ib, t);
            if (t !== ib) errs++;
        end
        chk("R3 idle passthrough mismatches", errs, 0);
    endtask

    task automatic t_tx_pattern();
        logic t;
        int e_wait = 0, e_pat = 0, e_tail = 0, e_idle = 0;
        while (sc % 16 != 5) step(1'b0, 1'b0, t);
        wr(1, 8'h2D);
        wr(0, 1);
        while (sc % 16 != 0) begin
            logic ib;
            ib = sc[0];
            step(1'b0, ib, t);
            if (t !== ib) e_wait++;
        end
        chk("R3 enable waits for boundary", e_wait, 0);
        for (int i = 0; i < 32; i++) begin
            step(1'b0, 1'b0, t);
            if (t !== pat_bit(i % 16, 6'h2D)) e_pat++;
        end
        chk("R2 pattern 0x2D two periods", e_pat, 0);
        for (int i = 0; i < 5; i++) begin
            step(1'b0, 1'b0, t);
            if (t !== pat_bit(i, 6'h2D)) e_tail++;
        end
        wr(0, 0);
        for (int i = 5; i < 16; i++) begin
            step(1'b0, 1'b1, t);
            if (t !== pat_bit(i, 6'h2D)) e_tail++;
        end
        chk("R3 disable completes pattern", e_tail, 0);
        for (int i = 0; i < 8; i++) begin
            logic ib;
            ib = (i % 2 == 0);
            step(1'b0, ib, t);
            if (t !== ib) e_idle++;
        end
        chk("R3 idle after boundary", e_idle, 0);
    endtask

    task automatic t_rx();
        int d;
        send_code(6'h15);
        rd(5, d); chk("R4 single pattern no event", d, 0);
        rd(4, d); chk("R4 single pattern not live", d, 0);
        send_code(6'h15);
        rd(5, d); chk("R4 event after second pattern", d, 1);
        rd(3, d); chk("R4 stored code", d, 6'h15);
        rd(4, d); chk("R4 live bit", d, 1);
        wr(5, 1);
        rd(5, d); chk("R8 write one clears", d, 0);
        send_code(6'h15);
        send_code(6'h15);
        rd(5, d); chk("R5 unchanged code no event", d, 0);
        send_code(6'h2A);
        send_code(6'h2A);
        rd(5, d); chk("R5 changed code event", d, 1);
        rd(3, d); chk("R5 changed code stored", d, 6'h2A);
        wr(5, 0);
        rd(5, d); chk("R8 write zero keeps bit", d, 1);
        wr(5, 1);
        send_gap();
        rd(4, d); chk("R6 live cleared on gap", d, 0);
        rd(3, d); chk("R6 code kept after loss", d, 6'h2A);
        send_code(6'h2A);
        send_code(6'h2A);
        rd(5, d); chk("R6 reacquire raises event", d, 1);
        wr(5, 3);
    endtask

    task automatic t_match();
        int d;
        wr(2, 6'h2A);
        rd(4, d); chk("R7 match live", d, 3);
        rd(5, d); chk("R7 match event from register write", d, 2);
        chk("R9 irq unmasked", int'(irq), 1);
        wr(6, 3);
        chk("R9 irq all masked", int'(irq), 0);
        wr(6, 1);
        chk("R9 irq match unmasked", int'(irq), 1);
        wr(6, 2);
        chk("R9 irq masked by bit1", int'(irq), 0);
        wr(6, 0);
        wr(5, 3);
        chk("R9 irq after clear", int'(irq), 0);
        send_gap();
        rd(4, d); chk("R7 match drops with loss", d, 0);
        send_code(6'h2A);
        send_code(6'h2A);
        rd(5, d); chk("R7 both events on reacquire", d, 3);
        chk("R9 irq set", int'(irq), 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_tx_idle();
        t_tx_pattern();
        t_rx();
        t_match();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule